// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous up counter built from identical 4-bit stages. Each stage counts modulo 16. The stages are chained so that the whole chain behaves as one binary counter of 4×N bits. Every stage shares one clock. Each stage passes a terminal-count signal to the next stage's trickle enable. A global parallel enable goes to every stage. As a result, a stage advances only on the cycle where all stages below it read all ones.

The counter can be preset from a parallel data bus. It resolves its four modes by a fixed priority: clear, then load, then count, then hold. A build-time parameter selects the clear style:

- **Asynchronous clear:** the count is forced to zero as soon as the clear input goes low, whatever the clock is doing.
- **Synchronous clear:** the clear takes effect on the next rising clock edge.

The final terminal count is combinational. It is high when the whole chain reads all ones and the trickle enable is high. Several of these blocks can therefore be chained in the same way as the stages inside one block.

All pins are plain control and status pins. There is no data stream and no handshake. Every input is sampled on each rising edge.

Top module: `casc_counter`

## Requirements
- R1: From the all-ones value, a count step returns the count to zero (modulo 2^(4×NUM_STAGES)). Within a stage, value 15 steps to 0.
- R2: With ASYNC_CLR=1, `rst_n` low forces `q` to zero without waiting for a clock edge. `q` stays zero while `rst_n` is low.
- R3: With ASYNC_CLR=0, `rst_n` low at a rising edge sets `q` to zero at that edge. A low `rst_n` between edges does not change `q`.
- R4: Modes resolve in the order clear, then load, then count, then hold. A low `rst_n` beats a low `load_n`, and a low `load_n` beats an active count.
- R5: With `rst_n` high and `load_n` low, the next rising edge copies `din` into `q`, whatever `cnt_en_p` and `cnt_en_t` are.
- R6: With `rst_n` and `load_n` high, `q` increments by one at a rising edge only when both `cnt_en_p` and `cnt_en_t` are high. Otherwise `q` holds.
- R7: The terminal count of each stage is high exactly when that stage's trickle enable is high and its 4-bit count is 15.
- R8: `tc` is high exactly when `cnt_en_t` is high and `q` is all ones. It follows `cnt_en_t` within the same cycle, without a clock edge.
- R9: Stage k (bits 4k+3..4k) increments only on a count step where all lower bits are ones, so the chain counts as one wide binary number.
- R10: Apart from the asynchronous clear, `q` changes only at a rising edge of `clk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low clear; asynchronous or synchronous per ASYNC_CLR |
| load_n | input | 1 | Active-low parallel preset enable |
| din | input | 4×NUM_STAGES | Preset value |
| cnt_en_p | input | 1 | Parallel count enable, fanned out to every stage |
| cnt_en_t | input | 1 | Trickle count enable of the first stage; also gates `tc` |
| q | output | 4×NUM_STAGES | Current count |
| tc | output | 1 | Terminal count of the last stage |

## Verification
A wrong internal state in any stage shows up on `q` at the next rising edge. The carry chain makes the error worse on later edges: a lower stage that is stuck or wraps wrongly enables the wrong upper stage on the following count step. A broken terminal-count path shows on `tc` within the same cycle that `cnt_en_t` changes, before any edge. A wrong clear style shows in one of two ways. An asynchronous build that waits for the clock shows a non-zero `q` in the half-cycle after `rst_n` falls. A synchronous build that clears early shows a zero `q` in that same window.

// File: rtl/cnt_pkg.sv
`timescale 1ns/1ps
package cnt_pkg;
  localparam int STAGE_W = 4;

  // Mode of one stage, listed from lowest to highest priority
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_COUNT = 2'd1,
    MODE_LOAD  = 2'd2,
    MODE_CLEAR = 2'd3
  } cnt_mode_e;
endpackage

// File: rtl/cnt_mode_dec.sv
`timescale 1ns/1ps
module cnt_mode_dec
  import cnt_pkg::*;
(
  input  logic      clr_n,
  input  logic      load_n,
  input  logic      cep,
  input  logic      cet,
  output cnt_mode_e mode
);
  // Fixed priority: clear, then load, then count, then hold (R4)
  always_comb begin
    if (!clr_n)          mode = MODE_CLEAR;
    else if (!load_n)    mode = MODE_LOAD;
    else if (cep && cet) mode = MODE_COUNT;
    else                 mode = MODE_HOLD;
  end
endmodule

// File: rtl/cnt_stage.sv
`timescale 1ns/1ps
module cnt_stage
  import cnt_pkg::*;
#(
  parameter int W         = STAGE_W,
  parameter bit ASYNC_CLR = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_n,
  input  logic         cep,
  input  logic         cet,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         tc
);
  localparam logic [W-1:0] TOP_VAL = '1;

  cnt_mode_e    mode;
  logic [W-1:0] q_next;

  cnt_mode_dec u_dec (
    .clr_n (rst_n),
    .load_n(load_n),
    .cep   (cep),
    .cet   (cet),
    .mode  (mode)
  );

  always_comb begin
    unique case (mode)
      MODE_CLEAR: q_next = '0;
      MODE_LOAD:  q_next = din;
      MODE_COUNT: q_next = q + W'(1);
      default:    q_next = q;
    endcase
  end

  generate
    if (ASYNC_CLR) begin : g_async
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= q_next;
      end

      AST_ASYNC_CLEAR: assert property (@(posedge clk) !rst_n |-> q == '0); // R2
    end else begin : g_sync
      always_ff @(posedge clk) begin
        q <= q_next;
      end

      AST_SYNC_CLEAR: assert property (@(posedge clk) !rst_n |=> q == '0); // R3
    end
  endgenerate

  // Terminal count: combinational from cet (R7)
  assign tc = cet && (q == TOP_VAL);

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && cep && cet && q == TOP_VAL) |=> q == '0); // R1
  AST_LOAD_TAKES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> q == $past(din)); // R5
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !(cep && cet)) |=> $stable(q)); // R6
endmodule

// File: rtl/casc_counter.sv
`timescale 1ns/1ps
module casc_counter
  import cnt_pkg::*;
#(
  parameter int NUM_STAGES = 2,
  parameter bit ASYNC_CLR  = 1'b0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load_n,
  input  logic [STAGE_W*NUM_STAGES-1:0] din,
  input  logic                          cnt_en_p,
  input  logic                          cnt_en_t,
  output logic [STAGE_W*NUM_STAGES-1:0] q,
  output logic                          tc
);
  localparam int W = STAGE_W * NUM_STAGES;

  // carry[i] is the trickle enable of stage i; carry[NUM_STAGES] is the final tc
  logic [NUM_STAGES:0] carry;
  assign carry[0] = cnt_en_t;

  generate
    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
      cnt_stage #(
        .W        (STAGE_W),
        .ASYNC_CLR(ASYNC_CLR)
      ) u_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .load_n(load_n),
        .cep   (cnt_en_p),
        .cet   (carry[i]),
        .din   (din[i*STAGE_W +: STAGE_W]),
        .q     (q[i*STAGE_W +: STAGE_W]),
        .tc    (carry[i+1])
      );
    end
  endgenerate

  assign tc = carry[NUM_STAGES];

  AST_TC_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> (cnt_en_t && (&q))); // R8
  AST_CHAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && cnt_en_p && cnt_en_t) |=> q == $past(q) + W'(1)); // R9
endmodule

// File: tb/sim_casc_counter.sv
`timescale 1ns/1ps
module sim_casc_counter;
  localparam int N = 2;
  localparam int W = 4 * N;

  logic         clk = 1'b0;
  logic         rst_n = 1'b1;
  logic         load_n = 1'b1;
  logic [W-1:0] din = '0;
  logic         cep = 1'b0;
  logic         cet = 1'b0;
  logic [W-1:0] q_s, q_a;
  logic         tc_s, tc_a;

  int checks = 0;
  int errs = 0;
  logic [W-1:0] exp_s, exp_a;

  always #10 clk = ~clk;

  // Synchronous-clear build
  casc_counter #(.NUM_STAGES(N), .ASYNC_CLR(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din),
    .cnt_en_p(cep), .cnt_en_t(cet), .q(q_s), .tc(tc_s));

  // Asynchronous-clear build
  casc_counter #(.NUM_STAGES(N), .ASYNC_CLR(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din),
    .cnt_en_p(cep), .cnt_en_t(cet), .q(q_a), .tc(tc_a));

  function automatic logic [W-1:0] nxt(logic [W-1:0] cur, logic r, logic l,
                                       logic [W-1:0] d, logic p, logic t);
    if (!r)          return '0;
    else if (!l)     return d;
    else if (p && t) return cur + W'(1);
    else             return cur;
  endfunction

  function automatic logic exp_tc(logic [W-1:0] cur, logic t);
    return t && (cur == '1);
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] expv);
    checks++;
    if (act !== expv) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // Called at a falling edge: drive, check combinational effects, clock, check
  task automatic step(logic r, logic l, logic p, logic t, logic [W-1:0] d, string tag);
    rst_n = r; load_n = l; cep = p; cet = t; din = d;
    #1;
    if (!r) exp_a = '0;
    chk({tag, " R2 async immediate"}, q_a, exp_a);
    chk({tag, " R10 sync before edge"}, q_s, exp_s);
    chk({tag, " R8 tc same cycle"}, {{(W-1){1'b0}}, tc_s}, {{(W-1){1'b0}}, exp_tc(exp_s, t)});
    exp_s = nxt(exp_s, r, l, d, p, t);
    exp_a = nxt(exp_a, r, l, d, p, t);
    @(negedge clk);
    chk({tag, " sync q"}, q_s, exp_s);
    chk({tag, " async q"}, q_a, exp_a);
    chk({tag, " R8 tc"}, {{(W-1){1'b0}}, tc_a}, {{(W-1){1'b0}}, exp_tc(exp_a, t)});
  endtask

  initial begin
    #(200000 * 20);
    errs++;
    checks++;
    $display("FAIL watchdog all-requirements actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

  initial begin
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'h1C0FFEE);
    #1 rst_n = 1'b0;
    #1;
    exp_a = '0;
    chk("R2 async clear before any edge", q_a, '0);
    @(negedge clk);
    @(negedge clk);
    exp_s = '0;
    chk("R3 reset state sync", q_s, '0);
    chk("R2 reset state async", q_a, '0);

    step(1, 0, 1, 1, 8'hFD, "R5 load");
    step(1, 1, 1, 1, 8'h00, "R6 count");
    step(1, 1, 1, 1, 8'h00, "R6 count to all ones");
    step(1, 1, 1, 0, 8'h00, "R6 hold cet low");
    step(1, 1, 1, 1, 8'h00, "R1 wrap");
    step(1, 0, 0, 0, 8'h0F, "R5 load ignores enables");
    step(1, 1, 1, 1, 8'h00, "R7/R9 carry into upper stage");
    step(1, 1, 0, 1, 8'h00, "R6 hold cep low");
    step(1, 0, 1, 1, 8'h5A, "R4 load over count");
    step(0, 0, 1, 1, 8'hA5, "R4 R3 clear over load");
    step(1, 0, 0, 0, 8'hFF, "R5 load all ones");
    step(1, 1, 0, 1, 8'h00, "R8 tc with cep low");
    step(1, 1, 0, 0, 8'h00, "R8 tc drops with cet");

    for (int i = 0; i < 4000; i++) begin
      logic r, l, p, t;
      r = ($urandom % 32) != 0;
      l = ($urandom % 8) != 0;
      p = ($urandom % 8) != 0;
      t = ($urandom % 8) != 0;
      step(r, l, p, t, W'($urandom), "R4 random");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule